// File: doc/BRIEF.md
# ID-Filtered Memory Port Event Tap

This block sits beside one memory port and watches three of its bus channels: read address, write address and read data. It never drives a ready signal. It only observes completed handshakes. For each kind of traffic it can raise a single-cycle event pulse. That happens only when the ID carried on the handshake agrees with a programmed ID in every bit position that a programmed mask selects. The three pulses are meant to feed fixed slots of a performance counter array: read transactions go to slot 2, write transactions to slot 3 and read data beats to slot 4. Those slots count the pulses when they are set to event code 73.

Software programs the block through a small write-only register port. The register at byte offset 0x00 holds three per-kind enable bits and the 18-bit mask. The register at byte offset 0x04 holds the 18-bit ID to match. The three kinds share one mask and one match ID, and each kind is switched on and off by its own enable bit.

The block applies no back-pressure. It never stalls or alters the channels it taps. A handshake counts only in a cycle where both valid and ready are high. A cycle with valid held high and ready low is not an event. The same transfer held over several cycles counts once, in the cycle where ready rises.

Top module: `axf_event_gen`

## Requirements
- R1: While reset is asserted and after it is released, all three event outputs are low. All enable bits, the mask and the match ID reset to zero, so no pulse appears until software sets an enable.
- R2: A write to byte offset 0x00 loads the enables from bit 31 (read transaction), bit 30 (write transaction) and bit 29 (read beat), and loads the mask from bits 17:0. A write to offset 0x04 loads the match ID from bits 17:0. A write to any other offset changes nothing.
- R3: An ID matches when (id AND mask) equals (match ID AND mask). A mask of zero therefore accepts every ID.
- R4: A read address handshake (ar_valid and ar_ready both high) with a matching ID, while bit 31 is set, gives evt_rd_txn high for exactly the following cycle.
- R5: A write address handshake (aw_valid and aw_ready both high) with a matching ID, while bit 30 is set, gives evt_wr_txn high for exactly the following cycle.
- R6: A read data handshake (r_valid and r_ready both high) with a matching ID, while bit 29 is set, gives evt_rd_beat high for exactly the following cycle.
- R7: A channel whose valid is high and whose ready is low produces no pulse, whatever its ID.
- R8: A kind whose enable bit is clear never raises its output, even for matching handshakes.
- R9: A configuration write takes effect for handshakes in the next cycle. A handshake in the same cycle as the write is judged against the configuration that was in place before the write.
- R10: The three kinds are independent. Handshakes on all three channels in the same cycle give all three pulses in the same following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Byte offset of the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| ar_valid | input | 1 | Read address valid (observed) |
| ar_ready | input | 1 | Read address ready (observed) |
| ar_id | input | 18 | Read address ID |
| aw_valid | input | 1 | Write address valid (observed) |
| aw_ready | input | 1 | Write address ready (observed) |
| aw_id | input | 18 | Write address ID |
| r_valid | input | 1 | Read data valid (observed) |
| r_ready | input | 1 | Read data ready (observed) |
| r_id | input | 18 | Read data ID |
| evt_rd_txn | output | 1 | Filtered read transaction pulse (counter slot 2) |
| evt_wr_txn | output | 1 | Filtered write transaction pulse (counter slot 3) |
| evt_rd_beat | output | 1 | Filtered read beat pulse (counter slot 4) |

## Verification
Directed patterns check the outputs under several conditions:
- a zero mask, under which every ID passes;
- a full mask, where an ID that differs in one bit from the match ID must be rejected;
- a partial mask, where a difference in the masked-off bits must be accepted.

Further directed cycles cover the remaining cases:
- valid held with ready low, which separates handshakes from mere requests;
- a single enable set, which shows the kinds do not leak into each other;
- a configuration write in the same cycle as a handshake, which tells apart "old configuration" from "new configuration" timing;
- a write to an unused offset, which must leave filtering unchanged.

Random cycles then mix per-channel valid and ready. Their IDs are either derived from the match ID with changes only in masked-off bits, or drawn freely. Occasional writes to random offsets change the configuration while the channels keep running.

// File: rtl/axf_pkg.sv
package axf_pkg;
  localparam int ID_W      = 18;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 4;
  localparam int NKIND     = 3;

  // register byte offsets
  localparam int OFS_FILT  = 0;
  localparam int OFS_MATCH = 4;

  // counter slots and select code the pulses are wired for
  localparam int EVT_CODE      = 73;
  localparam int SLOT_RD_TXN   = 2;
  localparam int SLOT_WR_TXN   = 3;
  localparam int SLOT_RD_BEAT  = 4;

  // kind index k takes its enable from bit (DATA_W-1-k) of the filter register
  typedef enum logic [1:0] {
    K_RD_TXN  = 2'd0,
    K_WR_TXN  = 2'd1,
    K_RD_BEAT = 2'd2
  } kind_e;
endpackage

// File: rtl/axf_cfg_regs.sv
module axf_cfg_regs #(
  parameter int ID_W   = axf_pkg::ID_W,
  parameter int DATA_W = axf_pkg::DATA_W,
  parameter int ADDR_W = axf_pkg::ADDR_W,
  parameter int NKIND  = axf_pkg::NKIND
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NKIND-1:0]  en,
  output logic [ID_W-1:0]   mask,
  output logic [ID_W-1:0]   match_id
);
  localparam logic [ADDR_W-1:0] A_FILT  = ADDR_W'(axf_pkg::OFS_FILT);
  localparam logic [ADDR_W-1:0] A_MATCH = ADDR_W'(axf_pkg::OFS_MATCH);
  localparam int EN_LO = DATA_W - NKIND;

  logic             hit_filt, hit_match;
  logic [NKIND-1:0] en_next;
  logic             unused_bits;

  assign hit_filt  = we && (addr == A_FILT);
  assign hit_match = we && (addr == A_MATCH);
  assign unused_bits = ^wdata[EN_LO-1:ID_W];

  // kind k lives at bit DATA_W-1-k
  for (genvar k = 0; k < NKIND; k++) begin : g_en
    assign en_next[k] = wdata[DATA_W-1-k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= '0;
      mask     <= '0;
      match_id <= '0;
    end else begin
      if (hit_filt) begin
        en   <= en_next;
        mask <= wdata[ID_W-1:0];
      end
      if (hit_match) begin
        match_id <= wdata[ID_W-1:0];
      end
    end
  end

  // R2
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr != A_FILT && addr != A_MATCH) |=>
      ($stable(en) && $stable(mask) && $stable(match_id)));
endmodule

// File: rtl/axf_id_match.sv
module axf_id_match #(
  parameter int ID_W = axf_pkg::ID_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [ID_W-1:0] mask,
  input  logic [ID_W-1:0] match_id,
  input  logic            hs_valid,
  input  logic            hs_ready,
  input  logic [ID_W-1:0] hs_id,
  output logic            pulse
);
  logic fire, id_ok;

  assign id_ok = ((hs_id ^ match_id) & mask) == '0;
  assign fire  = hs_valid && hs_ready && en && id_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= 1'b0;
    else        pulse <= fire;
  end

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !pulse);

  // R7
  no_handshake_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_valid && hs_ready) |=> !pulse);

  // R3
  zero_mask_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hs_valid && hs_ready && mask == '0) |=> pulse);

  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(hs_valid && hs_ready));
endmodule

// File: rtl/axf_event_gen.sv
module axf_event_gen #(
  parameter int ID_W   = axf_pkg::ID_W,
  parameter int DATA_W = axf_pkg::DATA_W,
  parameter int ADDR_W = axf_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  output logic              evt_rd_txn,
  output logic              evt_wr_txn,
  output logic              evt_rd_beat
);
  localparam int NKIND = axf_pkg::NKIND;

  logic [NKIND-1:0] en, vld, rdy, pls;
  logic [ID_W-1:0]  mask, match_id;
  logic [ID_W-1:0]  ids [NKIND];

  axf_cfg_regs #(.ID_W(ID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NKIND(NKIND)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en(en), .mask(mask), .match_id(match_id)
  );

  assign vld[axf_pkg::K_RD_TXN]  = ar_valid;
  assign rdy[axf_pkg::K_RD_TXN]  = ar_ready;
  assign ids[axf_pkg::K_RD_TXN]  = ar_id;
  assign vld[axf_pkg::K_WR_TXN]  = aw_valid;
  assign rdy[axf_pkg::K_WR_TXN]  = aw_ready;
  assign ids[axf_pkg::K_WR_TXN]  = aw_id;
  assign vld[axf_pkg::K_RD_BEAT] = r_valid;
  assign rdy[axf_pkg::K_RD_BEAT] = r_ready;
  assign ids[axf_pkg::K_RD_BEAT] = r_id;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    axf_id_match #(.ID_W(ID_W)) u_match (
      .clk(clk), .rst_n(rst_n), .en(en[k]), .mask(mask), .match_id(match_id),
      .hs_valid(vld[k]), .hs_ready(rdy[k]), .hs_id(ids[k]), .pulse(pls[k])
    );
  end

  assign evt_rd_txn  = pls[axf_pkg::K_RD_TXN];
  assign evt_wr_txn  = pls[axf_pkg::K_WR_TXN];
  assign evt_rd_beat = pls[axf_pkg::K_RD_BEAT];

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pls == '0));
endmodule

// File: tb/sim_axf_event_gen.sv
module sim_axf_event_gen;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic ar_valid = 1'b0, ar_ready = 1'b0, aw_valid = 1'b0, aw_ready = 1'b0;
  logic r_valid = 1'b0, r_ready = 1'b0;
  logic [IW-1:0] ar_id = '0, aw_id = '0, r_id = '0;
  logic evt_rd_txn, evt_wr_txn, evt_rd_beat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [2:0]    m_en = '0;
  logic [IW-1:0] m_mask = '0;
  logic [IW-1:0] m_id = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axf_event_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
    .evt_rd_txn(evt_rd_txn), .evt_wr_txn(evt_wr_txn), .evt_rd_beat(evt_rd_beat)
  );

  function automatic bit fmatch(input logic [IW-1:0] id, input logic [IW-1:0] msk,
                                input logic [IW-1:0] mid);
    return (id & msk) == (mid & msk);
  endfunction

  function automatic bit fexp(input bit en, input bit v, input bit r, input logic [IW-1:0] id);
    return en && v && r && fmatch(id, m_mask, m_id);
  endfunction

  task automatic check(input string tag, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
    end
  endtask

  task automatic idle();
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    ar_valid = 1'b0; ar_ready = 1'b0; aw_valid = 1'b0; aw_ready = 1'b0;
    r_valid = 1'b0; r_ready = 1'b0;
  endtask

  // inputs already set; compute expectation, clock, check at the next falling edge
  task automatic step(input string t0, input string t1, input string t2);
    bit e0, e1, e2;
    e0 = fexp(m_en[0], ar_valid, ar_ready, ar_id);
    e1 = fexp(m_en[1], aw_valid, aw_ready, aw_id);
    e2 = fexp(m_en[2], r_valid, r_ready, r_id);
    if (cfg_we && cfg_addr == 4'h0) begin
      m_en = {cfg_wdata[29], cfg_wdata[30], cfg_wdata[31]};
      m_mask = cfg_wdata[IW-1:0];
    end else if (cfg_we && cfg_addr == 4'h4) begin
      m_id = cfg_wdata[IW-1:0];
    end
    @(posedge clk);
    @(negedge clk);
    check(t0, "evt_rd_txn", evt_rd_txn, e0);
    check(t1, "evt_wr_txn", evt_wr_txn, e1);
    check(t2, "evt_rd_beat", evt_rd_beat, e2);
    idle();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5eed_0a1f));
    idle();
    repeat (3) @(negedge clk);
    // R1: outputs low in reset even with handshakes present
    ar_valid = 1; ar_ready = 1; aw_valid = 1; aw_ready = 1; r_valid = 1; r_ready = 1;
    @(negedge clk);
    check("R1", "evt_rd_txn", evt_rd_txn, 1'b0);
    check("R1", "evt_wr_txn", evt_wr_txn, 1'b0);
    check("R1", "evt_rd_beat", evt_rd_beat, 1'b0);
    rst_n = 1'b1;
    // R1: enables reset to zero, so handshakes after release are filtered out
    ar_valid = 1; ar_ready = 1; aw_valid = 1; aw_ready = 1; r_valid = 1; r_ready = 1;
    step("R1", "R1", "R1");

    // R9: write all enables, mask zero, same cycle as handshakes -> old config applies
    wr(4'h0, 32'hE000_0000);
    ar_valid = 1; ar_ready = 1; ar_id = 18'h1234;
    step("R9", "R9", "R9");
    // R3/R10: zero mask accepts any ID, all three at once
    ar_valid = 1; ar_ready = 1; ar_id = 18'h3FFFF;
    aw_valid = 1; aw_ready = 1; aw_id = 18'h00001;
    r_valid = 1; r_ready = 1; r_id = 18'h2AAAA;
    step("R3", "R10", "R10");

    // R2: program match ID and a full mask
    wr(4'h4, 32'hFFFE_A5A5);  // ID field 17:0 = 0x2A5A5
    step("R2", "R2", "R2");
    wr(4'h0, 32'hE003_FFFF);
    step("R2", "R2", "R2");
    // R4 matching ID pulses; R3 single bit off rejected
    ar_valid = 1; ar_ready = 1; ar_id = 18'h2A5A5;
    aw_valid = 1; aw_ready = 1; aw_id = 18'h2A5A4;
    r_valid = 1; r_ready = 1; r_id = 18'h0A5A5;
    step("R4", "R3", "R3");
    // R6/R5 matching beats and writes
    r_valid = 1; r_ready = 1; r_id = 18'h2A5A5;
    aw_valid = 1; aw_ready = 1; aw_id = 18'h2A5A5;
    step("R4", "R5", "R6");
    // R7: valid without ready
    ar_valid = 1; ar_id = 18'h2A5A5; aw_valid = 1; aw_id = 18'h2A5A5;
    r_valid = 1; r_id = 18'h2A5A5;
    step("R7", "R7", "R7");
    // R2: write to offset 0x8 ignored; filtering unchanged
    wr(4'h8, 32'h0000_0000);
    step("R2", "R2", "R2");
    ar_valid = 1; ar_ready = 1; ar_id = 18'h2A5A5;
    r_valid = 1; r_ready = 1; r_id = 18'h2A5A5;
    aw_valid = 1; aw_ready = 1; aw_id = 18'h1A5A5;
    step("R2", "R2", "R2");
    // R3: partial mask, upper bits ignored
    wr(4'h0, 32'hE000_00FF);
    step("R2", "R2", "R2");
    ar_valid = 1; ar_ready = 1; ar_id = 18'h000A5;
    aw_valid = 1; aw_ready = 1; aw_id = 18'h3FFA5;
    r_valid = 1; r_ready = 1; r_id = 18'h2A5A4;
    step("R3", "R3", "R3");
    // R8: only write-transaction enable (bit 30)
    wr(4'h0, 32'h4000_0000);
    step("R8", "R8", "R8");
    ar_valid = 1; ar_ready = 1; aw_valid = 1; aw_ready = 1; r_valid = 1; r_ready = 1;
    step("R8", "R5", "R8");
    // R9: disabling write takes effect only after the write cycle
    wr(4'h0, 32'h0000_0000);
    aw_valid = 1; aw_ready = 1;
    step("R9", "R9", "R9");
    aw_valid = 1; aw_ready = 1;
    step("R8", "R8", "R8");

    // random traffic with occasional configuration writes
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 16) == 0) begin
        logic [3:0] a;
        a = 4'(($urandom % 4) * 4);
        wr(a, $urandom);
      end
      ar_valid = $urandom % 2; ar_ready = $urandom % 2;
      aw_valid = $urandom % 2; aw_ready = $urandom % 2;
      r_valid = $urandom % 2; r_ready = $urandom % 2;
      ar_id = ($urandom % 2) ? (m_id ^ (IW'($urandom) & ~m_mask)) : IW'($urandom);
      aw_id = ($urandom % 2) ? (m_id ^ (IW'($urandom) & ~m_mask)) : IW'($urandom);
      r_id  = ($urandom % 2) ? (m_id ^ (IW'($urandom) & ~m_mask)) : IW'($urandom);
      step("R4", "R5", "R6");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule